// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block holds the time of day and the calendar as seven BCD bytes: seconds, minutes, hours, date, month, day of week and year. It advances once for each cycle in which a one-per-second tick enable is high. The tick is expected to come from a prescaler on a low-frequency oscillator; the block itself runs on the system clock. Each carry passes from seconds up to the year within the same clock cycle. Month lengths and leap years are handled, so the date always rolls over on the real last day of the month.

The hours byte works in either 24-hour or 12-hour form, selected by its top bit. In 12-hour form it carries an AM/PM flag. The top bit of the seconds byte is a halt flag that freezes the whole count. A register interface next to the block writes any field through a per-field load strobe and a shared data byte. It reads all fields at once through parallel outputs.

Top module: `bcd_calendar_timer`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00 (24-hour mode), date 01, month 01, day of week 01, year 00.
- R2: Seconds and minutes count in BCD from 00 to 59. A seconds value of 59 becomes 00 on the next tick and increments minutes. Minutes at 59 wrap the same way and increment hours.
- R3: With hours bit 7 = 0 (24-hour mode), bits 5:0 count 00 to 23 in BCD. Bit 5 serves as the tens-of-twenty bit. The step from 23 goes to 00 and advances the date.
- R4: With hours bit 7 = 1 (12-hour mode), bits 4:0 run 12, 01, 02, …, 11 and back to 12. Bit 5 is the PM flag (1 = PM) and inverts on each step from 11 to 12. Stepping from 11 PM to 12 AM advances the date.
- R5: The date rolls to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except 02. Each rollover advances the month.
- R6: February ends on 29 when the BCD year value is a multiple of 4 (year 00 included) and on 28 otherwise.
- R7: Month 12 rolls to 01 and advances the year. The year counts 00 to 99 in BCD and wraps to 00.
- R8: Day of week counts 1 to 7 and wraps to 1, advancing exactly when the date advances.
- R9: While seconds bit 7 is 1, ticks change no field. Writing it back to 0 resumes counting.
- R10: A write strobe for any field in a cycle loads that field and cancels the tick of that cycle for every field.
- R11: Written values are masked per field: seconds 0xFF, minutes 0x7F, hours 0xBF, date 0x3F, month 0x1F, day of week 0x07, year 0xFF.
- R12: With no tick and no write, no field changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle enable per elapsed second |
| wr_en | input | 7 | Per-field load strobes: 0 sec, 1 min, 2 hour, 3 date, 4 month, 5 day of week, 6 year |
| wr_data | input | 8 | Value loaded into the strobed field |
| sec_q | output | 8 | Seconds in BCD, bit 7 halt flag |
| min_q | output | 8 | Minutes in BCD |
| hour_q | output | 8 | Hours: bit 7 mode, bit 5 PM or tens-of-twenty, BCD below |
| date_q | output | 8 | Day of month in BCD |
| month_q | output | 8 | Month in BCD |
| dow_q | output | 8 | Day of week 1 to 7 |
| year_q | output | 8 | Year in BCD |

## Verification
The carry chain is tested from times preset one tick before a boundary. Single-digit carries (09 to 10) separate BCD stepping from binary stepping. The x9:59:59 and 23:59:59 points separate correct minute and hour propagation from a chain that stops early. The 12-hour cases cover 11 AM, 12 PM, and 11 PM as the starting hour, which separates the AM/PM toggle point from the 12-to-01 wrap. Every year from 00 to 99 is run through 28 February. End-of-month dates are tried for short months, long months and December, and tick-with-write and halted ticks show that counting is suppressed.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int NUM_FIELDS = 7;
  localparam int F_SEC   = 0;
  localparam int F_MIN   = 1;
  localparam int F_HOUR  = 2;
  localparam int F_DATE  = 3;
  localparam int F_MONTH = 4;
  localparam int F_DOW   = 5;
  localparam int F_YEAR  = 6;

  typedef logic [7:0] bcd8_t;

  function automatic bcd8_t field_mask(input int idx);
    case (idx)
      F_MIN:   return 8'h7F;
      F_HOUR:  return 8'hBF;
      F_DATE:  return 8'h3F;
      F_MONTH: return 8'h1F;
      F_DOW:   return 8'h07;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic bcd8_t field_reset(input int idx);
    case (idx)
      F_DATE, F_MONTH, F_DOW: return 8'h01;
      default:                return 8'h00;
    endcase
  endfunction

  // Add one to a two-digit BCD value (no wrap handling at 99).
  function automatic bcd8_t bcd_inc(input bcd8_t v);
    if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
    return {v[7:4], v[3:0] + 4'h1};
  endfunction

  // Seconds/minutes successor, 59 wraps to 00, upper bits cleared.
  function automatic bcd8_t mod60_next(input bcd8_t v);
    if (v[6:0] == 7'h59) return 8'h00;
    return bcd_inc({1'b0, v[6:0]});
  endfunction

  // Divisible by four: even tens need units 0/4/8, odd tens need 2/6.
  function automatic logic is_leap(input bcd8_t y);
    if (y[4]) return (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
    return (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
  endfunction

  function automatic bcd8_t last_day(input bcd8_t m, input bcd8_t y);
    case (m[4:0])
      5'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic hour_day_end(input bcd8_t h);
    if (h[7]) return h[5] && (h[4:0] == 5'h11);
    return h[5:0] == 6'h23;
  endfunction

  function automatic bcd8_t hour_next(input bcd8_t h);
    bcd8_t t;
    if (h[7]) begin
      if (h[4:0] == 5'h12) return {2'b10, h[5], 5'h01};
      if (h[4:0] == 5'h11) return {2'b10, ~h[5], 5'h12};
      t = bcd_inc({3'b000, h[4:0]});
      return {2'b10, h[5], t[4:0]};
    end
    if (h[5:0] == 6'h23) return 8'h00;
    return bcd_inc({2'b00, h[5:0]});
  endfunction
endpackage

// File: rtl/rtc_field_reg.sv
module rtc_field_reg
  import rtc_cal_pkg::*;
#(
  parameter bcd8_t MASK      = 8'hFF,
  parameter bcd8_t RESET_VAL = 8'h00
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  bcd8_t load_val,
  input  logic  step,
  input  bcd8_t step_val,
  output bcd8_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RESET_VAL;
    else if (load) q <= load_val & MASK;
    else if (step) q <= step_val & MASK;
  end
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_cal_pkg::*;
(
  input  logic  run,
  input  bcd8_t sec,
  input  bcd8_t min,
  input  bcd8_t hour,
  output bcd8_t sec_nxt,
  output bcd8_t min_nxt,
  output bcd8_t hour_nxt,
  output logic  sec_carry,
  output logic  min_carry,
  output logic  day_carry
);
  always_comb begin
    sec_nxt   = mod60_next(sec);
    min_nxt   = mod60_next(min);
    hour_nxt  = hour_next(hour);
    sec_carry = run && (sec[6:0] == 7'h59);
    min_carry = sec_carry && (min[6:0] == 7'h59);
    day_carry = min_carry && hour_day_end(hour);
  end
endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
  import rtc_cal_pkg::*;
(
  input  logic  day_carry,
  input  bcd8_t date,
  input  bcd8_t month,
  input  bcd8_t dow,
  input  bcd8_t year,
  output bcd8_t date_nxt,
  output bcd8_t month_nxt,
  output bcd8_t dow_nxt,
  output bcd8_t year_nxt,
  output logic  month_carry,
  output logic  year_carry
);
  bcd8_t month_end;
  logic  at_end;

  always_comb begin
    month_end   = last_day(month, year);
    at_end      = (date[5:0] == month_end[5:0]);
    date_nxt    = at_end ? 8'h01 : bcd_inc({2'b00, date[5:0]});
    dow_nxt     = (dow[2:0] >= 3'd7) ? 8'h01 : {5'b0, dow[2:0] + 3'd1};
    month_nxt   = (month[4:0] == 5'h12) ? 8'h01 : bcd_inc({3'b000, month[4:0]});
    year_nxt    = (year == 8'h99) ? 8'h00 : bcd_inc(year);
    month_carry = day_carry && at_end;
    year_carry  = month_carry && (month[4:0] == 5'h12);
  end
endmodule

// File: rtl/bcd_calendar_timer.sv
module bcd_calendar_timer
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1hz,
  input  logic [6:0] wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_q,
  output logic [7:0] min_q,
  output logic [7:0] hour_q,
  output logic [7:0] date_q,
  output logic [7:0] month_q,
  output logic [7:0] dow_q,
  output logic [7:0] year_q
);
  bcd8_t [NUM_FIELDS-1:0] fq;
  bcd8_t [NUM_FIELDS-1:0] fnxt;
  logic  [NUM_FIELDS-1:0] fstep;

  logic run;
  logic sec_carry, min_carry, day_carry, month_carry, year_carry;

  // A halted clock or any register write drops this cycle's tick.
  assign run = tick_1hz && !fq[F_SEC][7] && (wr_en == '0);

  rtc_time_chain u_time (
    .run       (run),
    .sec       (fq[F_SEC]),
    .min       (fq[F_MIN]),
    .hour      (fq[F_HOUR]),
    .sec_nxt   (fnxt[F_SEC]),
    .min_nxt   (fnxt[F_MIN]),
    .hour_nxt  (fnxt[F_HOUR]),
    .sec_carry (sec_carry),
    .min_carry (min_carry),
    .day_carry (day_carry)
  );

  rtc_date_chain u_date (
    .day_carry   (day_carry),
    .date        (fq[F_DATE]),
    .month       (fq[F_MONTH]),
    .dow         (fq[F_DOW]),
    .year        (fq[F_YEAR]),
    .date_nxt    (fnxt[F_DATE]),
    .month_nxt   (fnxt[F_MONTH]),
    .dow_nxt     (fnxt[F_DOW]),
    .year_nxt    (fnxt[F_YEAR]),
    .month_carry (month_carry),
    .year_carry  (year_carry)
  );

  assign fstep[F_SEC]   = run;
  assign fstep[F_MIN]   = sec_carry;
  assign fstep[F_HOUR]  = min_carry;
  assign fstep[F_DATE]  = day_carry;
  assign fstep[F_DOW]   = day_carry;
  assign fstep[F_MONTH] = month_carry;
  assign fstep[F_YEAR]  = year_carry;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    rtc_field_reg #(
      .MASK      (field_mask(i)),
      .RESET_VAL (field_reset(i))
    ) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_en[i]),
      .load_val (wr_data),
      .step     (fstep[i]),
      .step_val (fnxt[i]),
      .q        (fq[i])
    );
  end

  assign sec_q   = fq[F_SEC];
  assign min_q   = fq[F_MIN];
  assign hour_q  = fq[F_HOUR];
  assign date_q  = fq[F_DATE];
  assign month_q = fq[F_MONTH];
  assign dow_q   = fq[F_DOW];
  assign year_q  = fq[F_YEAR];
endmodule

// File: rtl/rtc_cal_checker.sv
module rtc_cal_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_1hz,
  input logic [6:0] wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] sec_q,
  input logic [7:0] min_q,
  input logic [7:0] hour_q,
  input logic [7:0] date_q,
  input logic [7:0] month_q,
  input logic [7:0] dow_q,
  input logic [7:0] year_q,
  input logic       sec_carry,
  input logic       min_carry,
  input logic       day_carry,
  input logic       month_carry
);
  logic [55:0] all_q;
  assign all_q = {sec_q, min_q, hour_q, date_q, month_q, dow_q, year_q};

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_1hz && wr_en == 7'b0) |=> $stable(all_q));

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q[7] && wr_en == 7'b0) |=> $stable(all_q));

  // R10
  sec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[0] |=> sec_q == $past(wr_data));

  // R11
  min_load_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[1] |=> min_q == ($past(wr_data) & 8'h7F));

  // R2
  min_only_on_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en[1] && !sec_carry) |=> $stable(min_q));

  // R3
  hour_only_on_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en[2] && !min_carry) |=> $stable(hour_q));

  // R4
  pm_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (min_carry && !wr_en[2] && hour_q[7] && hour_q[4:0] == 5'h11)
      |=> (hour_q[5] != $past(hour_q[5])) && hour_q[4:0] == 5'h12);

  // R5
  month_roll_date_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (month_carry && !wr_en[3]) |=> date_q == 8'h01);

  // R8
  dow_follows_day_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en[5]) |=> ($changed(dow_q) == $past(day_carry)));
endmodule

bind bcd_calendar_timer rtc_cal_checker u_rtc_cal_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_1hz    (tick_1hz),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .sec_q       (sec_q),
  .min_q       (min_q),
  .hour_q      (hour_q),
  .date_q      (date_q),
  .month_q     (month_q),
  .dow_q       (dow_q),
  .year_q      (year_q),
  .sec_carry   (sec_carry),
  .min_carry   (min_carry),
  .day_carry   (day_carry),
  .month_carry (month_carry)
);

// File: tb/bcd_calendar_timer_test.sv
module bcd_calendar_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic [6:0] wr_en = 7'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] sec_q, min_q, hour_q, date_q, month_q, dow_q, year_q;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bcd_calendar_timer uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_1hz (tick_1hz),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .sec_q    (sec_q),
    .min_q    (min_q),
    .hour_q   (hour_q),
    .date_q   (date_q),
    .month_q  (month_q),
    .dow_q    (dow_q),
    .year_q   (year_q)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic put(input int idx, input logic [7:0] v);
    @(negedge clk);
    wr_en = 7'b1 << idx;
    wr_data = v;
    @(negedge clk);
    wr_en = 7'b0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_1hz = 1'b1;
      @(negedge clk);
      tick_1hz = 1'b0;
    end
  endtask

  task automatic preset(input logic [7:0] yr, input logic [7:0] mo, input logic [7:0] dt,
                        input logic [7:0] dw, input logic [7:0] hr, input logic [7:0] mi,
                        input logic [7:0] se);
    put(6, yr); put(4, mo); put(3, dt); put(5, dw); put(2, hr); put(1, mi); put(0, se);
  endtask

  task automatic t_reset;
    chk("R1", "sec", sec_q, 8'h00);
    chk("R1", "min", min_q, 8'h00);
    chk("R1", "hour", hour_q, 8'h00);
    chk("R1", "date", date_q, 8'h01);
    chk("R1", "month", month_q, 8'h01);
    chk("R1", "dow", dow_q, 8'h01);
    chk("R1", "year", year_q, 8'h00);
  endtask

  task automatic t_idle;
    repeat (20) @(negedge clk);
    chk("R12", "sec idle", sec_q, 8'h00);
    chk("R12", "date idle", date_q, 8'h01);
  endtask

  task automatic t_sec_min;
    pulse(5);
    chk("R2", "sec after 5", sec_q, 8'h05);
    put(0, 8'h09); pulse(1);
    chk("R2", "sec 09->10", sec_q, 8'h10);
    put(1, 8'h07); put(0, 8'h59); pulse(1);
    chk("R2", "sec wrap", sec_q, 8'h00);
    chk("R2", "min carry", min_q, 8'h08);
    put(2, 8'h09); put(1, 8'h59); put(0, 8'h59); pulse(1);
    chk("R2", "min wrap", min_q, 8'h00);
    chk("R3", "hour 09->10", hour_q, 8'h10);
  endtask

  task automatic t_24h;
    preset(8'h21, 8'h03, 8'h15, 8'h07, 8'h19, 8'h59, 8'h59); pulse(1);
    chk("R3", "hour 19->20", hour_q, 8'h20);
    chk("R3", "date kept", date_q, 8'h15);
    put(2, 8'h23); put(1, 8'h59); put(0, 8'h59); pulse(1);
    chk("R3", "hour 23->00", hour_q, 8'h00);
    chk("R3", "date step", date_q, 8'h16);
    chk("R8", "dow 7->1", dow_q, 8'h01);
    put(2, 8'h23); put(1, 8'h59); put(0, 8'h59); pulse(1);
    chk("R8", "dow 1->2", dow_q, 8'h02);
  endtask

  task automatic t_12h;
    preset(8'h21, 8'h05, 8'h10, 8'h03, 8'h91, 8'h59, 8'h59); pulse(1);
    chk("R4", "11AM->12PM", hour_q, 8'hB2);
    chk("R4", "date kept", date_q, 8'h10);
    put(1, 8'h59); put(0, 8'h59); pulse(1);
    chk("R4", "12PM->01PM", hour_q, 8'hA1);
    put(2, 8'hB1); put(1, 8'h59); put(0, 8'h59); pulse(1);
    chk("R4", "11PM->12AM", hour_q, 8'h92);
    chk("R4", "date step", date_q, 8'h11);
    chk("R8", "dow step", dow_q, 8'h04);
    put(1, 8'h59); put(0, 8'h59); pulse(1);
    chk("R4", "12AM->01AM", hour_q, 8'h81);
  endtask

  task automatic t_month_len;
    preset(8'h21, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59); pulse(1);
    chk("R5", "apr30 date", date_q, 8'h01);
    chk("R5", "apr30 month", month_q, 8'h05);
    preset(8'h21, 8'h01, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59); pulse(1);
    chk("R5", "jan30 date", date_q, 8'h31);
    chk("R5", "jan30 month", month_q, 8'h01);
    put(2, 8'h23); put(1, 8'h59); put(0, 8'h59); pulse(1);
    chk("R5", "jan31 date", date_q, 8'h01);
    chk("R5", "jan31 month", month_q, 8'h02);
    preset(8'h21, 8'h11, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59); pulse(1);
    chk("R5", "nov30 month", month_q, 8'h12);
  endtask

  task automatic t_leap;
    for (int y = 0; y < 100; y++) begin
      logic [7:0] yb;
      logic [7:0] exp_date;
      logic [7:0] exp_month;
      yb = 8'((y / 10) * 16 + (y % 10));
      exp_date  = (y % 4 == 0) ? 8'h29 : 8'h01;
      exp_month = (y % 4 == 0) ? 8'h02 : 8'h03;
      preset(yb, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59); pulse(1);
      chk("R6", $sformatf("feb28 y%0d date", y), date_q, exp_date);
      chk("R6", $sformatf("feb28 y%0d month", y), month_q, exp_month);
    end
    preset(8'h00, 8'h02, 8'h29, 8'h01, 8'h23, 8'h59, 8'h59); pulse(1);
    chk("R6", "feb29 y00", month_q, 8'h03);
  endtask

  task automatic t_year;
    preset(8'h19, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59); pulse(1);
    chk("R7", "dec31 month", month_q, 8'h01);
    chk("R7", "dec31 year 19->20", year_q, 8'h20);
    preset(8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59); pulse(1);
    chk("R7", "year 99->00", year_q, 8'h00);
    chk("R7", "date", date_q, 8'h01);
    chk("R8", "dow", dow_q, 8'h06);
  endtask

  task automatic t_halt;
    put(0, 8'h85); pulse(4);
    chk("R9", "halted sec", sec_q, 8'h85);
    put(0, 8'hD9); put(1, 8'h59); pulse(2);
    chk("R9", "halted at 59 sec", sec_q, 8'hD9);
    chk("R9", "halted at 59 min", min_q, 8'h59);
    put(0, 8'h05); pulse(3);
    chk("R9", "resumed sec", sec_q, 8'h08);
  endtask

  task automatic t_priority;
    put(0, 8'h10); put(1, 8'h20);
    @(negedge clk);
    tick_1hz = 1'b1; wr_en = 7'b0000010; wr_data = 8'h30;
    @(negedge clk);
    tick_1hz = 1'b0; wr_en = 7'b0;
    chk("R10", "written min", min_q, 8'h30);
    chk("R10", "sec not ticked", sec_q, 8'h10);
    put(0, 8'h59);
    @(negedge clk);
    tick_1hz = 1'b1; wr_en = 7'b0001000; wr_data = 8'h07;
    @(negedge clk);
    tick_1hz = 1'b0; wr_en = 7'b0;
    chk("R10", "sec 59 held", sec_q, 8'h59);
    chk("R10", "min no carry", min_q, 8'h30);
  endtask

  task automatic t_mask;
    put(1, 8'hFF); chk("R11", "min mask", min_q, 8'h7F);
    put(2, 8'hFF); chk("R11", "hour mask", hour_q, 8'hBF);
    put(3, 8'hFF); chk("R11", "date mask", date_q, 8'h3F);
    put(4, 8'hFF); chk("R11", "month mask", month_q, 8'h1F);
    put(5, 8'hFF); chk("R11", "dow mask", dow_q, 8'h07);
    put(6, 8'hFF); chk("R11", "year mask", year_q, 8'hFF);
    put(0, 8'hFF); chk("R11", "sec mask", sec_q, 8'hFF);
    put(0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_idle;
    t_sec_min;
    t_24h;
    t_12h;
    t_month_len;
    t_leap;
    t_year;
    t_halt;
    t_priority;
    t_mask;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule